// File: doc/BRIEF.md
# Per-Queue Packet Ready Tracker

This block sits beside a multi-queue FIFO that runs in packet mode. Every word moving through the FIFO carries a start mark and an end mark, set by the user to frame packets. The tracker sees each accepted write (target queue, start mark, end mark) and each read (source queue, end mark). From these it keeps, for every queue, a count of whole packets held and a flag for whether a packet is open on the write side. The data itself never passes through the tracker.

Its outputs are a registered packet-ready vector with one bit per queue and the ready bit of the queue the read port currently selects. The read side uses these in place of an empty flag, so it can start a read only when a whole packet is waiting. A partial reset clears one queue, and the active-low reset clears all queues. Packet tracking only makes sense when both FIFO ports are full width, so an enable input, tied to that configuration, gates all updates.

Top module: `pkt_ready_tracker`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it, every bit of pkt_rdy_o, rd_pkt_rdy_o and frame_err_o is 0. All packet counts and open-packet states are cleared.
- R2: A write carrying an end mark adds one to the count of its queue, provided a packet is open there or the same word carries a start mark. The count saturates at 2^CNT_W-1. A start mark on a queue with no open packet opens one. A word with both marks is a one-word packet.
- R3: A read carrying an end mark takes one from the count of its queue. At a count of zero the read leaves the count at zero.
- R4: When a counted end-mark write and an end-mark read hit the same queue in the same cycle, that queue's count does not change.
- R5: A write with a start mark to a queue that already has an open packet is a framing error. frame_err_o is 1 in the following cycle, the count does not change (even if the word also carries an end mark), and the packet stays open.
- R6: A write with an end mark and no start mark to a queue with no open packet is ignored.
- R7: When prst_i is high, the queue addressed by prst_q_i has its count and open state cleared, and this overrides any event on that queue in the same cycle. Other queues are unaffected.
- R8: Bit q of pkt_rdy_o is a register. After a clock edge it is 1 exactly when pkt_en_i was high and queue q's count was nonzero just before that edge, so it lags the count by one cycle.
- R9: rd_pkt_rdy_o equals pkt_rdy_o[rd_q_i] combinationally.
- R10: While pkt_en_i is low, writes and reads change no count or open state and raise no framing error, and pkt_rdy_o is 0 after the next edge. Partial reset still acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of all queues |
| pkt_en_i | input | 1 | Packet tracking enable (both ports full width) |
| wr_en_i | input | 1 | A word is accepted on the write port this cycle |
| wr_q_i | input | QW | Queue addressed by the write |
| wr_sop_i | input | 1 | Start mark of the written word |
| wr_eop_i | input | 1 | End mark of the written word |
| rd_en_i | input | 1 | A word is removed on the read port this cycle |
| rd_q_i | input | QW | Queue selected on the read port |
| rd_eop_i | input | 1 | End mark of the word being read |
| prst_i | input | 1 | Partial reset strobe |
| prst_q_i | input | QW | Queue cleared by the partial reset |
| pkt_rdy_o | output | NQ | Registered packet-ready flag per queue |
| rd_pkt_rdy_o | output | 1 | Ready flag of the queue selected by rd_q_i |
| frame_err_o | output | 1 | Registered pulse on a start mark into an open packet |

## Verification
The assertions assume that wr_q_i, rd_q_i and prst_q_i address queues below NQ, and that reads with end marks come from a FIFO holding whole packets. The tracker cannot check the second assumption itself, so the properties are written to tolerate a stray end-mark read at a count of zero. The stimulus uses a power-of-two queue count, so every address is valid. It sweeps the write and read fields over all combinations, including stray reads. The bench's own model follows the same floor-at-zero rule, so the expected values stay valid under any stimulus.

// File: rtl/pkt_trk_pkg.sv
package pkt_trk_pkg;
  typedef struct packed {
    logic hit;
    logic sop;
    logic eop;
  } wr_ev_t;
endpackage

// File: rtl/pkt_sel_decode.sv
module pkt_sel_decode #(
  parameter int N  = 32,
  parameter int AW = 5
) (
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output logic [N-1:0]  sel_o
);
  for (genvar i = 0; i < N; i++) begin : g_sel
    assign sel_o[i] = en_i && (addr_i == AW'(i));
  end
endmodule

// File: rtl/pkt_q_slot.sv
module pkt_q_slot import pkt_trk_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  wr_ev_t wr_i,
  input  logic   rd_eop_hit_i,
  input  logic   clr_i,
  output logic   rdy_o,
  output logic   err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             open_q, rdy_q;
  logic             err, start_ok, close, dec_req;

  assign err      = en_i && wr_i.hit && wr_i.sop && open_q;
  assign start_ok = en_i && wr_i.hit && wr_i.sop && !open_q;
  // end mark counts only when it closes a packet open now or opened by this word
  assign close    = en_i && wr_i.hit && wr_i.eop && !err && (open_q || wr_i.sop);
  assign dec_req  = en_i && rd_eop_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= en_i && (cnt_q != '0);
      if (clr_i) begin
        cnt_q  <= '0;
        open_q <= 1'b0;
      end else begin
        if (close)         open_q <= 1'b0;
        else if (start_ok) open_q <= 1'b1;
        if (close && !dec_req) begin
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end else if (dec_req && !close && cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign rdy_o = rdy_q;
  assign err_o = err;

  // R7
  clr_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0) && !open_q);
  // R4
  same_cycle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close && dec_req && !clr_i) |=> $stable(cnt_q));
  // R5
  err_keeps_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err && !clr_i) |=> open_q);
  // R2
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close && !dec_req && !clr_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R3
  floor_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_req && !close && !clr_i && cnt_q == '0) |=> cnt_q == '0);
  // R10
  disabled_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q) && $stable(open_q) && !rdy_q);
endmodule

// File: rtl/pkt_ready_tracker.sv
module pkt_ready_tracker import pkt_trk_pkg::*; #(
  parameter  int NQ    = 32,
  parameter  int CNT_W = 8,
  localparam int QW    = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pkt_en_i,
  input  logic          wr_en_i,
  input  logic [QW-1:0] wr_q_i,
  input  logic          wr_sop_i,
  input  logic          wr_eop_i,
  input  logic          rd_en_i,
  input  logic [QW-1:0] rd_q_i,
  input  logic          rd_eop_i,
  input  logic          prst_i,
  input  logic [QW-1:0] prst_q_i,
  output logic [NQ-1:0] pkt_rdy_o,
  output logic          rd_pkt_rdy_o,
  output logic          frame_err_o
);
  logic [NQ-1:0] wr_sel, rd_sel, clr_sel, err_vec;
  logic          err_q;

  pkt_sel_decode #(.N(NQ), .AW(QW)) i_wr_dec (
    .en_i(wr_en_i), .addr_i(wr_q_i), .sel_o(wr_sel));
  pkt_sel_decode #(.N(NQ), .AW(QW)) i_rd_dec (
    .en_i(rd_en_i && rd_eop_i), .addr_i(rd_q_i), .sel_o(rd_sel));
  pkt_sel_decode #(.N(NQ), .AW(QW)) i_clr_dec (
    .en_i(prst_i), .addr_i(prst_q_i), .sel_o(clr_sel));

  for (genvar q = 0; q < NQ; q++) begin : g_q
    wr_ev_t ev;
    assign ev.hit = wr_sel[q];
    assign ev.sop = wr_sop_i;
    assign ev.eop = wr_eop_i;
    pkt_q_slot #(.CNT_W(CNT_W)) i_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (pkt_en_i),
      .wr_i         (ev),
      .rd_eop_hit_i (rd_sel[q]),
      .clr_i        (clr_sel[q]),
      .rdy_o        (pkt_rdy_o[q]),
      .err_o        (err_vec[q])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= |err_vec;
  end

  assign frame_err_o  = err_q;
  assign rd_pkt_rdy_o = pkt_rdy_o[rd_q_i];

  // R5
  err_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_err_o) |-> $past(pkt_en_i && wr_en_i && wr_sop_i));
  // R5
  err_single_q_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(err_vec));
endmodule

// File: tb/test_pkt_ready_tracker.sv
module test_pkt_ready_tracker;
  localparam int NQ = 4;
  localparam int CW = 3;
  localparam int QW = 2;
  localparam int CMAX = 7;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pkt_en_i = 1'b0, wr_en_i = 1'b0, wr_sop_i = 1'b0, wr_eop_i = 1'b0;
  logic rd_en_i = 1'b0, rd_eop_i = 1'b0, prst_i = 1'b0;
  logic [QW-1:0] wr_q_i = '0, rd_q_i = '0, prst_q_i = '0;
  logic [NQ-1:0] pkt_rdy_o;
  logic rd_pkt_rdy_o, frame_err_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_cnt [NQ];
  bit m_open [NQ];
  logic [NQ-1:0] e_rdy = '0;
  logic e_err = 1'b0;

  always #10 clk = ~clk;

  pkt_ready_tracker #(.NQ(NQ), .CNT_W(CW)) i_pkt_ready_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .pkt_en_i(pkt_en_i),
    .wr_en_i(wr_en_i), .wr_q_i(wr_q_i), .wr_sop_i(wr_sop_i), .wr_eop_i(wr_eop_i),
    .rd_en_i(rd_en_i), .rd_q_i(rd_q_i), .rd_eop_i(rd_eop_i),
    .prst_i(prst_i), .prst_q_i(prst_q_i),
    .pkt_rdy_o(pkt_rdy_o), .rd_pkt_rdy_o(rd_pkt_rdy_o), .frame_err_o(frame_err_o));

  task automatic check(string lbl, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", lbl, what, act, exp);
    end
  endtask

  task automatic check_outs(string lbl);
    check(lbl, "pkt_rdy_o", 32'(pkt_rdy_o), 32'(e_rdy));
    check(lbl, "frame_err_o", 32'(frame_err_o), 32'(e_err));
    check(lbl, "rd_pkt_rdy_o", 32'(rd_pkt_rdy_o), 32'(e_rdy[rd_q_i]));
  endtask

  task automatic model_clear();
    for (int q = 0; q < NQ; q++) begin
      m_cnt[q] = 0;
      m_open[q] = 0;
    end
    e_rdy = '0;
    e_err = 1'b0;
  endtask

  // check previous effect, then drive one cycle and advance the model
  task automatic step(string lbl, bit en, bit we, int wq, bit sop, bit eop,
                      bit re, int rq, bit reop, bit pr = 0, int pq = 0);
    logic [NQ-1:0] nrdy;
    logic nerr;
    @(negedge clk);
    check_outs(lbl);
    pkt_en_i = en; wr_en_i = we; wr_q_i = QW'(wq); wr_sop_i = sop; wr_eop_i = eop;
    rd_en_i = re; rd_q_i = QW'(rq); rd_eop_i = reop; prst_i = pr; prst_q_i = QW'(pq);
    nerr = 1'b0;
    for (int q = 0; q < NQ; q++) begin
      bit hw, er, cl, dr;
      nrdy[q] = en && (m_cnt[q] != 0);
      hw = en && we && (wq == q);
      er = hw && sop && m_open[q];
      cl = hw && eop && !er && (m_open[q] || sop);
      dr = en && re && reop && (rq == q);
      nerr |= er;
      if (pr && pq == q) begin
        m_cnt[q] = 0;
        m_open[q] = 0;
      end else begin
        if (cl) m_open[q] = 0;
        else if (hw && sop && !m_open[q]) m_open[q] = 1;
        if (cl && !dr) begin
          if (m_cnt[q] < CMAX) m_cnt[q]++;
        end else if (dr && !cl && m_cnt[q] > 0) m_cnt[q]--;
      end
    end
    e_rdy = nrdy;
    e_err = nerr;
  endtask

  task automatic idle(string lbl, int n = 1, bit en = 1);
    for (int k = 0; k < n; k++) step(lbl, en, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    model_clear();
    #1 check_outs("R1");
    @(negedge clk);
    check_outs("R1");
    rst_ni = 1'b1;
  endtask

  initial begin
    model_clear();
    do_reset();
    idle("R1", 2);
    // multi-word packet on q2: sop, body, eop
    step("R2", 1, 1, 2, 1, 0, 0, 0, 0);
    step("R2", 1, 1, 2, 0, 0, 0, 0, 0);
    step("R2", 1, 1, 2, 0, 1, 0, 2, 0);
    idle("R8", 3);
    // read it out
    step("R3", 1, 0, 0, 0, 0, 1, 2, 0);
    step("R3", 1, 0, 0, 0, 0, 1, 2, 1);
    idle("R3", 2);
    step("R3", 1, 0, 0, 0, 0, 1, 2, 1);   // stray read at zero
    idle("R3", 2);
    // single-word packets to q1 until saturated
    for (int k = 0; k < 9; k++) step("R2", 1, 1, 1, 1, 1, 0, 1, 0);
    idle("R9", 2);
    for (int k = 0; k < 3; k++) step("R9", 1, 0, 0, 0, 0, 0, k, 0);
    // simultaneous on q1
    step("R4", 1, 1, 1, 1, 1, 1, 1, 1);
    idle("R4", 2);
    for (int k = 0; k < 8; k++) step("R3", 1, 0, 0, 0, 0, 1, 1, 1);
    idle("R8", 2);
    // framing error on q3
    step("R5", 1, 1, 3, 1, 0, 0, 0, 0);
    step("R5", 1, 1, 3, 1, 1, 0, 0, 0);
    idle("R5", 2);
    step("R5", 1, 1, 3, 0, 1, 0, 0, 0);
    idle("R5", 2);
    // stray end mark on q0
    step("R6", 1, 1, 0, 0, 1, 0, 0, 0);
    idle("R6", 2);
    // partial reset overrides a same-cycle close
    step("R7", 1, 1, 0, 1, 0, 0, 0, 0);
    step("R7", 1, 1, 2, 1, 1, 0, 0, 0);
    step("R7", 1, 1, 0, 0, 1, 0, 0, 0, 1, 0);
    idle("R7", 2);
    step("R7", 1, 0, 0, 0, 0, 0, 0, 0, 1, 2);
    idle("R7", 2);
    // disabled
    step("R10", 1, 1, 1, 1, 1, 0, 0, 0);
    idle("R10", 1);
    for (int k = 0; k < 4; k++) step("R10", 0, 1, 1, 1, k[0], 1, 1, 1);
    idle("R10", 2);
    // near-exhaustive sweep
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] b = 12'(i);
      step("R8", b[11:8] != 4'h7, 1, int'(b[1:0]), b[2], b[3], b[7], int'(b[5:4]), b[6],
           b[11:8] == 4'hF, int'(b[9:8]));
    end
    idle("R8", 2);
    do_reset();
    idle("R1", 2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule